// File: doc/BRIEF.md
# DAC Sample Queue and Trigger Controller

This block sits between a simple register port and a 12-bit digital-to-analog converter. Software writes samples into a 32-entry first-in first-out queue. Each trigger, either a manual strobe written by software or a rising edge on an external trigger pin, takes the oldest sample from the queue and drives it onto the converter output, which holds that value until the next accepted trigger.

After each accepted trigger, a settling timer holds a busy indication for a programmable number of clock cycles, in steps of 25 cycles. Sticky flags record queue overflow, queue underflow, end of settling (done) and triggers that arrive too early. Software clears each flag by writing one to it. A separate strobe empties the queue. A global enable gates all triggers.

Register map (word addresses on `reg_addr`): 0 trigger control, 1 mode, 2 status (read), 3 sample data (write), 4 flags (read), 5 flag clear (write), 6 queue clear (write).

Top module: `dac_feed_ctrl`

## Requirements
- R1: A write to address 3 while the queue is not full appends bits [11:0] of `reg_wdata` and ignores the upper bits. Status bits [5:0] at address 2 read the current entry count, from 0 to 32.
- R2: Each accepted trigger moves the oldest queued sample to `dac_out` on the same clock edge, so samples leave in the order they were written. `dac_out` resets to 0.
- R3: A sample write while 32 entries are held and no pop happens in that cycle is dropped, and sets flag bit 0 (overflow).
- R4: A trigger while the block is enabled, not busy and the queue is empty leaves `dac_out` unchanged and sets flag bit 1 (underflow).
- R5: Mode bits [3:1] at address 1 select a settling code. After an accepted trigger, status bit 8 (busy) stays high for 25×code cycles. Code 7 behaves like code 6 (150 cycles). Code 0 never raises busy.
- R6: Flag bit 2 (done) is set on the edge where busy falls. With code 0, it is set on the edge of the accepted trigger.
- R7: A trigger while busy does not pop, leaves `dac_out` unchanged and sets flag bit 3 (trigger error).
- R8: While mode bit 0 (enable) is 0, triggers pop nothing, change no output and set no flag. Sample writes are still accepted.
- R9: Writing address 0 with bit 0 set is a manual trigger. Bit 1 of address 0 is stored as the external-trigger enable. While it is set, each rising edge of `ext_trig` is one trigger. A level held high does not trigger again. While it is clear, `ext_trig` is ignored.
- R10: Writing address 5 clears each flag whose bit is 1 and leaves the others unchanged. A flag that is set and cleared in the same cycle ends up set.
- R11: Writing address 6 with bit 0 set empties the queue at once. A sample write or trigger in that cycle sees an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ext_trig | input | 1 | External trigger, active on rising edge |
| dac_out | output | 12 | Sample presented to the converter |

## Verification
The trigger path is driven with several patterns:
- Manual strobes against a filled queue check order and value.
- Strobes against an empty queue, against a busy timer and against a disabled block each have to raise exactly their own flag, or none, while `dac_out` stays put.
- A held-high external trigger separates edge detection from level sensing.
- Settling codes 2 and 7 are measured cycle by cycle. They show whether busy lasts exactly 25×code cycles and whether the out-of-range code saturates.
- Filling past 32 entries and then draining the queue shows which write was dropped.

// File: rtl/dac_feed_ctrl.sv
module dac_feed_ctrl #(
  parameter int SAMPLE_W    = 12,
  parameter int DEPTH       = 32,
  parameter int SETTLE_STEP = 25,
  parameter int CODE_MAX    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [2:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                ext_trig,
  output logic [SAMPLE_W-1:0] dac_out
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int TMR_W = $clog2(SETTLE_STEP * CODE_MAX + 1);

  localparam logic [2:0] A_TRIG = 3'd0, A_MODE = 3'd1, A_STAT = 3'd2, A_DATA = 3'd3,
                         A_FLAG = 3'd4, A_FCLR = 3'd5, A_QCLR = 3'd6;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    fill;
  logic                ext_en, enable, ext_prev;
  logic [2:0]          code;
  logic [TMR_W-1:0]    tmr;
  logic [3:0]          flags;

  wire man_trig  = reg_we && reg_addr == A_TRIG && reg_wdata[0];
  wire ext_pulse = ext_en && ext_trig && !ext_prev;
  wire trig      = enable && (man_trig || ext_pulse);
  wire q_clr     = reg_we && reg_addr == A_QCLR && reg_wdata[0];
  wire push_req  = reg_we && reg_addr == A_DATA;
  wire busy      = tmr != '0;
  wire empty     = fill == '0;
  wire full      = fill == CNT_W'(DEPTH);

  wire pop    = trig && !busy && !empty && !q_clr;
  wire udf_ev = trig && !busy && (empty || q_clr);
  wire terr_ev = trig && busy;
  wire push   = push_req && !q_clr && (!full || pop);
  wire ovf_ev = push_req && !q_clr && full && !pop;

  wire [2:0]       code_sat   = (code > 3'(CODE_MAX)) ? 3'(CODE_MAX) : code;
  wire [TMR_W-1:0] settle_len = TMR_W'(code_sat) * TMR_W'(SETTLE_STEP);
  wire             done_ev    = (tmr == TMR_W'(1)) || (pop && settle_len == '0);

  wire [3:0] flag_set = {terr_ev, done_ev, udf_ev, ovf_ev};
  wire [3:0] flag_clr = (reg_we && reg_addr == A_FCLR) ? reg_wdata[3:0] : 4'b0;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= reg_wdata[SAMPLE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (q_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      fill <= fill + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en   <= 1'b0;
      enable   <= 1'b0;
      code     <= '0;
      ext_prev <= 1'b0;
      tmr      <= '0;
      flags    <= '0;
      dac_out  <= '0;
    end else begin
      ext_prev <= ext_trig;
      if (reg_we && reg_addr == A_TRIG) ext_en <= reg_wdata[1];
      if (reg_we && reg_addr == A_MODE) begin
        enable <= reg_wdata[0];
        code   <= reg_wdata[3:1];
      end
      if (pop) begin
        dac_out <= mem[rd_ptr];
        tmr     <= settle_len;
      end else if (busy) begin
        tmr <= tmr - 1'b1;
      end
      flags <= (flags & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TRIG:  reg_rdata[1]       = ext_en;
      A_MODE:  reg_rdata[3:0]     = {code, enable};
      A_STAT:  begin
        reg_rdata[CNT_W-1:0] = fill;
        reg_rdata[8]         = busy;
      end
      A_FLAG:  reg_rdata[3:0]     = flags;
      default: reg_rdata          = '0;
    endcase
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) fill <= CNT_W'(DEPTH));
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop && !q_clr) |=> (flags[0] && fill == CNT_W'(DEPTH)));
  // R5
  settle_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (tmr == $past(tmr) - 1'b1));
  // R6
  done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == TMR_W'(1)) |=> (!busy && flags[2]));
  // R7
  trig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> (flags[3] && $stable(dac_out)));
  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && (man_trig || ext_pulse) && !q_clr && !push_req) |=> ($stable(dac_out) && $stable(fill)));
endmodule

// File: tb/dac_feed_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_feed_ctrl_tb_top;
  logic        clk = 0, rst_n = 0, reg_we = 0, ext_trig = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [11:0] dac_out;
  int n_chk = 0, n_fail = 0;
  bit  done_flag = 0;

  always #4 clk = ~clk;

  dac_feed_ctrl dut_i (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .ext_trig, .dac_out);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2, d); check("R1 reset count/busy", d, 0);
    rd(4, d); check("R6 reset flags", d, 0);
    check("R2 reset dac_out", 32'(dac_out), 0);
  endtask

  task automatic t_order_mask;
    logic [31:0] d;
    wr(1, 1);
    wr(3, 32'h0000_0A11); wr(3, 32'hFFFF_F123); wr(3, 32'h0000_0333);
    rd(2, d); check("R1 count after 3 pushes", d, 3);
    wr(0, 1); check("R2 first pop", 32'(dac_out), 32'hA11);
    rd(4, d); check("R6 done with code 0", d, 4);
    rd(2, d); check("R5 code 0 never busy", d, 2);
    wr(0, 1); check("R1 upper bits ignored", 32'(dac_out), 32'h123);
    wr(0, 1); check("R2 third pop", 32'(dac_out), 32'h333);
    wr(5, 32'hF);
  endtask

  task automatic t_underflow;
    logic [31:0] d;
    wr(0, 1);
    check("R4 dac unchanged", 32'(dac_out), 32'h333);
    rd(4, d); check("R4 underflow flag only", d, 2);
    wr(5, 32'hF);
  endtask

  task automatic t_settle(input logic [2:0] code, input int cycles);
    logic [31:0] d;
    wr(1, {28'b0, code, 1'b1});
    wr(3, 32'h5A5);
    wr(0, 1);
    rd(2, d); check("R5 busy after trigger", d[8], 1);
    repeat (cycles - 1) @(negedge clk);
    rd(2, d); check("R5 busy on last cycle", d[8], 1);
    rd(4, d); check("R6 no done yet", d[2], 0);
    @(negedge clk);
    rd(2, d); check("R5 busy fell", d[8], 0);
    rd(4, d); check("R6 done on fall", d, 4);
    wr(5, 32'hF);
  endtask

  task automatic t_trig_busy;
    logic [31:0] d;
    wr(1, 32'h3);
    wr(3, 32'h111); wr(3, 32'h222);
    wr(0, 1);
    wr(0, 1);
    check("R7 dac unchanged", 32'(dac_out), 32'h111);
    rd(2, d); check("R7 no pop while busy", d[5:0], 1);
    rd(4, d); check("R7 trigger error flag", d[3], 1);
    repeat (30) @(negedge clk);
    wr(5, 32'h4);
    rd(4, d); check("R10 only done cleared", d, 32'h8);
    wr(5, 32'hF);
    rd(4, d); check("R10 all cleared", d, 0);
    wr(1, 1); wr(0, 1); wr(5, 32'hF);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    wr(1, 1);
    for (int i = 0; i < 33; i++) wr(3, 32'(i * 3 + 5));
    rd(2, d); check("R3 count saturates at 32", d, 32);
    rd(4, d); check("R3 overflow flag", d, 1);
    for (int i = 0; i < 32; i++) begin
      wr(0, 1);
      check("R2 drain order", 32'(dac_out), 32'(i * 3 + 5));
    end
    rd(2, d); check("R3 drained empty", d, 0);
    wr(5, 32'hF);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    wr(1, 0);
    wr(3, 32'h777);
    wr(0, 1);
    check("R8 dac unchanged", 32'(dac_out), 32'(31 * 3 + 5));
    rd(2, d); check("R8 push accepted, no pop", d, 1);
    rd(4, d); check("R8 no flags", d, 0);
    wr(1, 1);
  endtask

  task automatic t_ext;
    logic [31:0] d;
    wr(3, 32'h888);
    wr(0, 2);
    @(negedge clk); ext_trig = 1;
    repeat (3) @(negedge clk);
    ext_trig = 0;
    check("R9 ext edge pops oldest", 32'(dac_out), 32'h777);
    rd(2, d); check("R9 held level pops once", d, 1);
    rd(0, d); check("R9 ext enable readback", d, 2);
    wr(0, 0);
    @(negedge clk); ext_trig = 1;
    @(negedge clk); ext_trig = 0;
    @(negedge clk);
    rd(2, d); check("R9 ext ignored when off", d, 1);
    wr(5, 32'hF);
  endtask

  task automatic t_qclr;
    logic [31:0] d;
    wr(3, 32'h999); wr(3, 32'hAAA);
    wr(6, 1);
    rd(2, d); check("R11 queue emptied", d, 0);
    wr(0, 1);
    rd(4, d); check("R11 trigger after clear underflows", d, 2);
    check("R11 dac unchanged", 32'(dac_out), 32'h777);
    wr(5, 32'hF);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order_mask();
    t_underflow();
    t_settle(3'd2, 50);
    t_settle(3'd7, 150);
    t_trig_busy();
    t_overflow();
    t_disabled();
    t_ext();
    t_qclr();
    report();
  end
endmodule